// File: doc/BRIEF.md
# Key-protected independent watchdog timer

This block is a watchdog timer that counts in its own slow clock domain and is controlled from the bus clock domain. Software talks to it through four word registers: a key register, a prescaler register, a reload register and a status register. Magic values written to the key register start the watchdog, open the prescaler and reload registers for writing, or refill the down-counter. Once started, the watchdog cannot be stopped by any register access. If software fails to refill the counter in time, the counter reaches zero and the block raises its watchdog reset output. That output stays high until the system reset arrives.

Prescaler and reload values are written on the bus side and carried into the watchdog clock through a toggle-and-acknowledge handshake. A busy flag per register shows that a transfer is still in flight. Key events (start and refill) cross by toggles through the same kind of synchronizer. A debug-freeze input, synchronized into the watchdog clock, holds the counter while the core is halted.

Top module: `keyed_watchdog`

## Requirements
- R1: After the system reset, the prescaler register reads 0, the reload register reads 0xFFF, the status register reads 0 and the watchdog reset output is low.
- R2: Register addresses are 0 for key, 1 for prescaler (3 bits), 2 for reload (12 bits) and 3 for status. Writes to the prescaler or reload register are ignored unless the key 0x5555 was written first.
- R3: A key write of any value other than 0xCCCC, 0x5555 or 0xAAAA withdraws the write access granted by 0x5555.
- R4: An accepted prescaler write sets status bit 0 and an accepted reload write sets status bit 1. The flag is visible on the next read and clears once the value has reached the watchdog domain, within 40 bus cycles when the watchdog clock is a quarter of the bus clock. A write to a register whose flag is still set is ignored.
- R5: Before the start key has been written, the counter does not run and the watchdog reset output stays low, even after a refill key.
- R6: Key 0xCCCC starts the counter from 0xFFF. After that, no key value stops the countdown.
- R7: Key 0xAAAA loads the reload value into the counter. Refilling at intervals shorter than the timeout keeps the watchdog reset output low.
- R8: Prescaler code p divides the watchdog clock by 4 shifted left by min(p,6), so codes 6 and 7 both give 256. The counter decrements once per divided period. When the counter of a started watchdog reaches 0, the watchdog reset output goes high.
- R9: Once high, the watchdog reset output stays high, including through refill keys, until the system reset input is asserted.
- R10: While the debug-freeze input is high, the counter holds its value and no timeout occurs. When the input is released, counting resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | System reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Registered read data, valid one bus cycle after rd_addr |
| wdg_clk | input | 1 | Independent watchdog clock |
| dbg_freeze | input | 1 | Holds the counter while high |
| wdg_reset | output | 1 | Watchdog reset request, held until rst |

## Verification
The hardest situation to reach from the ports is a write that lands while the previous value of the same register is still crossing into the watchdog clock. The bench reaches it by issuing a second reload write right after the first, reading status while the flag is still up, and then reading back the register once the flag has dropped. Timeout behaviour is observed only through the reset output. The bench therefore picks a short reload value and samples in windows that separate a divide-by-4 timeout from a divide-by-8 one, and that separate the start value 0xFFF from the reload value.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int KEY_W = 16;
  localparam int PSC_W = 3;
  localparam int DIV_W = 9;   // holds 256-1
  localparam int MAX_SHIFT = 6;

  localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_FEED   = 16'hAAAA;

  localparam logic [1:0] ADDR_KEY  = 2'd0;
  localparam logic [1:0] ADDR_PSC  = 2'd1;
  localparam logic [1:0] ADDR_RLD  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  // Last value of the divider for a prescaler code: (4 << min(code,6)) - 1
  function automatic logic [DIV_W-1:0] div_last(input logic [PSC_W-1:0] code);
    logic [PSC_W-1:0] sh;
    sh = (code > PSC_W'(MAX_SHIFT)) ? PSC_W'(MAX_SHIFT) : code;
    return (DIV_W'(4) << sh) - DIV_W'(1);
  endfunction
endpackage

// File: rtl/kwd_sync.sv
module kwd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [KEY_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [KEY_W-1:0] rd_data,
  output logic [PSC_W-1:0] psc_q,
  output logic [CNT_W-1:0] rld_q,
  output logic             psc_tgl,
  output logic             rld_tgl,
  output logic             start_tgl,
  output logic             feed_tgl,
  input  logic             psc_ack,
  input  logic             rld_ack
);
  logic unlocked;
  logic psc_busy, rld_busy;
  logic wr_key, wr_psc, wr_rld;

  assign wr_key   = wr_en && (wr_addr == ADDR_KEY);
  assign wr_psc   = wr_en && (wr_addr == ADDR_PSC);
  assign wr_rld   = wr_en && (wr_addr == ADDR_RLD);
  assign psc_busy = psc_tgl ^ psc_ack;
  assign rld_busy = rld_tgl ^ rld_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked  <= 1'b0;
      psc_q     <= '0;
      rld_q     <= '1;
      psc_tgl   <= 1'b0;
      rld_tgl   <= 1'b0;
      start_tgl <= 1'b0;
      feed_tgl  <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (wr_key) begin
        case (wr_data)
          KEY_UNLOCK: unlocked  <= 1'b1;
          KEY_START:  start_tgl <= ~start_tgl;
          KEY_FEED:   feed_tgl  <= ~feed_tgl;
          default:    unlocked  <= 1'b0;
        endcase
      end
      if (wr_psc && unlocked && !psc_busy) begin
        psc_q   <= wr_data[PSC_W-1:0];
        psc_tgl <= ~psc_tgl;
      end
      if (wr_rld && unlocked && !rld_busy) begin
        rld_q   <= wr_data[CNT_W-1:0];
        rld_tgl <= ~rld_tgl;
      end
      case (rd_addr)
        ADDR_PSC:  rd_data <= KEY_W'(psc_q);
        ADDR_RLD:  rd_data <= KEY_W'(rld_q);
        ADDR_STAT: rd_data <= KEY_W'({rld_busy, psc_busy});
        default:   rd_data <= '0;
      endcase
    end
  end

  // R2: locked writes leave the registers untouched
  a_r2_locked_psc: assert property (@(posedge clk) disable iff (rst)
    (wr_psc && !unlocked) |=> $stable(psc_q));
  a_r2_locked_rld: assert property (@(posedge clk) disable iff (rst)
    (wr_rld && !unlocked) |=> $stable(rld_q));
  // R3: a stray key withdraws the write access
  a_r3_relock: assert property (@(posedge clk) disable iff (rst)
    (wr_key && wr_data != KEY_UNLOCK && wr_data != KEY_START && wr_data != KEY_FEED)
    |=> !unlocked);
  // R4: a write during a transfer is dropped
  a_r4_busy_drop: assert property (@(posedge clk) disable iff (rst)
    (wr_rld && rld_busy) |=> $stable(rld_q));
endmodule

// File: rtl/kwd_core.sv
module kwd_core
  import kwd_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int SYNC_N = 2
) (
  input  logic             wclk,
  input  logic             rst,
  input  logic             frz,
  input  logic [PSC_W-1:0] psc_q,
  input  logic [CNT_W-1:0] rld_q,
  input  logic             psc_tgl,
  input  logic             rld_tgl,
  input  logic             start_tgl,
  input  logic             feed_tgl,
  output logic             psc_ack,
  output logic             rld_ack,
  output logic             fired
);
  localparam int NSIG = 6;
  // bit 0 reset, 1 prescaler, 2 reload, 3 start, 4 feed, 5 freeze
  logic [NSIG-1:0] raw, syn;
  logic [3:0]      seen;
  logic            rst_w, frz_s;
  logic            psc_ev, rld_ev, start_ev, feed_ev;
  logic [PSC_W-1:0] psc_w;
  logic [CNT_W-1:0] rld_w, cnt;
  logic [DIV_W-1:0] div;
  logic             running;

  assign raw = {frz, feed_tgl, start_tgl, rld_tgl, psc_tgl, rst};

  for (genvar i = 0; i < NSIG; i++) begin : g_sync
    kwd_sync #(.STAGES(SYNC_N)) u_sync (.clk(wclk), .d(raw[i]), .q(syn[i]));
  end

  assign rst_w    = syn[0];
  assign frz_s    = syn[5];
  assign psc_ev   = syn[1] ^ seen[0];
  assign rld_ev   = syn[2] ^ seen[1];
  assign start_ev = syn[3] ^ seen[2];
  assign feed_ev  = syn[4] ^ seen[3];
  assign psc_ack  = seen[0];
  assign rld_ack  = seen[1];

  always_ff @(posedge wclk) begin
    if (rst_w) begin
      seen    <= '0;
      psc_w   <= '0;
      rld_w   <= '1;
      cnt     <= '1;
      div     <= '0;
      running <= 1'b0;
      fired   <= 1'b0;
    end else begin
      seen <= syn[4:1];
      if (psc_ev) psc_w <= psc_q;
      if (rld_ev) rld_w <= rld_q;
      if (start_ev) begin
        running <= 1'b1;
        cnt     <= '1;
        div     <= '0;
      end else if (feed_ev) begin
        cnt <= rld_w;
        div <= '0;
      end else if (running && !frz_s && !fired) begin
        if (div == div_last(psc_w)) begin
          div <= '0;
          if (cnt != '0) cnt <= cnt - CNT_W'(1);
        end else begin
          div <= div + DIV_W'(1);
        end
      end
      if (running && cnt == '0) fired <= 1'b1;
    end
  end

  // R9: the reset request never drops on its own
  a_r9_fire_sticky: assert property (@(posedge wclk) disable iff (rst_w)
    fired |=> fired);
  // R6: nothing stops a started watchdog
  a_r6_run_sticky: assert property (@(posedge wclk) disable iff (rst_w)
    running |=> running);
  // R10: frozen counter holds
  a_r10_freeze_hold: assert property (@(posedge wclk) disable iff (rst_w)
    (frz_s && !start_ev && !feed_ev) |=> $stable(cnt));
  // R5: counter idle before start
  a_r5_idle_hold: assert property (@(posedge wclk) disable iff (rst_w)
    (!running && !start_ev && !feed_ev) |=> $stable(cnt));
  // R8: the counter never wraps below zero
  a_r8_no_wrap: assert property (@(posedge wclk) disable iff (rst_w)
    (cnt == '0 && !start_ev && !feed_ev) |=> cnt == '0);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int SYNC_N = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [15:0] rd_data,
  input  logic        wdg_clk,
  input  logic        dbg_freeze,
  output logic        wdg_reset
);
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] rld_q;
  logic psc_tgl, rld_tgl, start_tgl, feed_tgl;
  logic psc_ack_w, rld_ack_w, psc_ack_b, rld_ack_b;

  kwd_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .psc_q(psc_q), .rld_q(rld_q),
    .psc_tgl(psc_tgl), .rld_tgl(rld_tgl), .start_tgl(start_tgl), .feed_tgl(feed_tgl),
    .psc_ack(psc_ack_b), .rld_ack(rld_ack_b)
  );

  kwd_sync #(.STAGES(SYNC_N)) u_psc_ack (.clk(clk), .d(psc_ack_w), .q(psc_ack_b));
  kwd_sync #(.STAGES(SYNC_N)) u_rld_ack (.clk(clk), .d(rld_ack_w), .q(rld_ack_b));

  kwd_core #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_core (
    .wclk(wdg_clk), .rst(rst), .frz(dbg_freeze), .psc_q(psc_q), .rld_q(rld_q),
    .psc_tgl(psc_tgl), .rld_tgl(rld_tgl), .start_tgl(start_tgl), .feed_tgl(feed_tgl),
    .psc_ack(psc_ack_w), .rld_ack(rld_ack_w), .fired(wdg_reset)
  );
endmodule

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;
  logic        clk = 1'b0, wdg_clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        dbg_freeze = 1'b0;
  logic        wdg_reset;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;       // 50 MHz bus clock
  always #40 wdg_clk = ~wdg_clk;

  keyed_watchdog u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wdg_clk(wdg_clk),
    .dbg_freeze(dbg_freeze), .wdg_reset(wdg_reset)
  );

  // op(1: write, 0: read) | addr | write data | expected read data
  localparam logic [34:0] VEC [10] = '{
    {1'b0, 2'd2, 16'h0000, 16'h0FFF},
    {1'b0, 2'd1, 16'h0000, 16'h0000},
    {1'b1, 2'd1, 16'h0005, 16'h0000},
    {1'b0, 2'd1, 16'h0000, 16'h0000},
    {1'b1, 2'd0, 16'h5555, 16'h0000},
    {1'b1, 2'd1, 16'h0003, 16'h0000},
    {1'b0, 2'd1, 16'h0000, 16'h0003},
    {1'b1, 2'd0, 16'h1234, 16'h0000},
    {1'b1, 2'd2, 16'h0050, 16'h0000},
    {1'b0, 2'd2, 16'h0000, 16'h0FFF}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_w(input int n);
    repeat (n) @(posedge wdg_clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (20) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic configure(input logic [2:0] p, input logic [11:0] r);
    bus_wr(2'd0, 16'h5555);
    bus_wr(2'd1, {13'd0, p});
    repeat (40) @(negedge clk);
    bus_wr(2'd2, {4'd0, r});
    repeat (40) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog timeout (R1..R10 run): cycles %0d expected below %0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    do_reset();

    // R1: reset state
    bus_rd(2'd3, v); check("R1 status after reset", v, 16'h0000);
    check("R1 wdg_reset after reset", {15'd0, wdg_reset}, 16'd0);

    // Register access vectors: R1, R2, R3
    for (int i = 0; i < 10; i++) begin
      string tag;
      tag = (i < 2) ? "R1 vector" : ((i < 7) ? "R2 vector" : "R3 vector");
      if (VEC[i][34]) begin
        bus_wr(VEC[i][33:32], VEC[i][31:16]);
      end else begin
        bus_rd(VEC[i][33:32], v);
        check($sformatf("%s %0d", tag, i), v, VEC[i][15:0]);
      end
    end

    // R4: busy flags and writes during a transfer
    do_reset();
    bus_wr(2'd0, 16'h5555);
    bus_wr(2'd2, 16'h0030);
    bus_wr(2'd2, 16'h0040);
    bus_rd(2'd3, v); check("R4 reload busy set", v, 16'h0002);
    repeat (40) @(negedge clk);
    bus_rd(2'd3, v); check("R4 reload busy clear", v, 16'h0000);
    bus_rd(2'd2, v); check("R4 write while busy ignored", v, 16'h0030);
    bus_wr(2'd1, 16'h0001);
    bus_rd(2'd3, v); check("R4 prescaler busy set", v, 16'h0001);
    repeat (40) @(negedge clk);
    bus_rd(2'd3, v); check("R4 prescaler busy clear", v, 16'h0000);

    // R5: refill without start never times out
    bus_wr(2'd0, 16'hAAAA);
    wait_w(400);
    check("R5 no reset before start", {15'd0, wdg_reset}, 16'd0);

    // R6, R7, R8, R9 with divide-by-4 and reload 0x20
    do_reset();
    configure(3'd0, 12'h020);
    bus_wr(2'd0, 16'hCCCC);
    wait_w(300);
    check("R6 start counts from 0xFFF", {15'd0, wdg_reset}, 16'd0);
    bus_wr(2'd0, 16'hAAAA);
    for (int k = 0; k < 4; k++) begin
      wait_w(60);
      bus_wr(2'd0, 16'hAAAA);
    end
    check("R7 periodic refill holds off reset", {15'd0, wdg_reset}, 16'd0);
    bus_wr(2'd0, 16'h0000);
    bus_wr(2'd0, 16'h1234);
    wait_w(200);
    check("R6/R8 timeout despite stray keys", {15'd0, wdg_reset}, 16'd1);
    bus_wr(2'd0, 16'hAAAA);
    wait_w(20);
    check("R9 reset held after refill", {15'd0, wdg_reset}, 16'd1);
    do_reset();
    check("R9 system reset clears output", {15'd0, wdg_reset}, 16'd0);

    // R8: divide-by-8 doubles the timeout
    configure(3'd1, 12'h020);
    bus_wr(2'd0, 16'hCCCC);
    bus_wr(2'd0, 16'hAAAA);
    wait_w(180);
    check("R8 divide-by-8 not yet expired", {15'd0, wdg_reset}, 16'd0);
    wait_w(150);
    check("R8 divide-by-8 expired", {15'd0, wdg_reset}, 16'd1);

    // R10: debug freeze
    do_reset();
    configure(3'd0, 12'h020);
    bus_wr(2'd0, 16'hCCCC);
    bus_wr(2'd0, 16'hAAAA);
    wait_w(10);
    dbg_freeze = 1'b1;
    wait_w(400);
    check("R10 frozen counter no reset", {15'd0, wdg_reset}, 16'd0);
    dbg_freeze = 1'b0;
    wait_w(200);
    check("R10 counting resumes after release", {15'd0, wdg_reset}, 16'd1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule